// File: doc/BRIEF.md
# Three-Phase Arithmetic Power Factor Meter

This block measures loading on a three-phase feeder. Each accepted sample carries one voltage and one current value for each of the phases R, S and T. The values are signed integers, normally scaled to per-unit times 1000 and arriving at 3840 samples per second. The block groups the samples into windows of 64. For each phase and window it forms the sum of squared voltage, the sum of squared current and the sum of voltage-current products.

At the end of each window, the block takes integer square roots of the six sums of squares through one shared sequential square-root unit, in the order R, S, T. It multiplies the voltage root of each phase by its current root and adds the three products to give the arithmetic apparent power. The active power is the sum of the three phase product sums. A shared sequential divider forms their ratio as a signed Q1.15 power factor.

A second ratio is formed over a programmable count of windows. It divides the accumulated active energy by the accumulated apparent energy. The same datapath returns the fundamental arithmetic power factor when it is fed with samples that carry only the fundamental. A window takes about 175 clock cycles to finish, so consecutive window ends must be further apart than that. At least four cycles between accepted samples gives enough spacing.

Top module: `arith_pf_meter`

## Requirements
- R1: A window closes on every 64th cycle with `smp_valid` high. Cycles with `smp_valid` low do not change any accumulated sum, whatever the sample inputs carry.
- R2: `win_p` is floor(Ptot / 64) as a signed value. Ptot is the sum, over the three phases, of the window's sums of v·i.
- R3: `win_s` is floor(Stot / 64). Stot is the sum, over the phases, of floor(sqrt(sum v²)) · floor(sqrt(sum i²)).
- R4: `win_pf` is a signed Q1.15 value. Its magnitude is min(32767, floor(|Ptot|·32768/Stot)) and it takes the sign of Ptot. It never equals -32768.
- R5: `win_valid` is a one-cycle pulse, given once per completed window. `win_pf`, `win_zero`, `win_p` and `win_s` keep their values between pulses.
- R6: When the denominator of a ratio is zero, that power factor output is 0 and its zero flag (`win_zero` or `avg_zero`) is 1. Otherwise the zero flag is 0.
- R7: After every N completed windows, `avg_pf` gives the R4 ratio taken over the Ptot and Stot sums of those N windows. This result comes with a one-cycle `avg_valid` pulse.
- R8: A cycle with `avg_n_wr` high loads N from `avg_n_in` and restarts the average with an empty sum and a count of zero. A written value of 0 is taken as 1. After reset, N is 4.
- R9: After reset, `win_valid` and `avg_valid` are low, and both power factor outputs and both zero flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| v_r | input | 16 | Phase R voltage sample, signed |
| v_s | input | 16 | Phase S voltage sample, signed |
| v_t | input | 16 | Phase T voltage sample, signed |
| i_r | input | 16 | Phase R current sample, signed |
| i_s | input | 16 | Phase S current sample, signed |
| i_t | input | 16 | Phase T current sample, signed |
| avg_n_wr | input | 1 | Load strobe for the averaging count |
| avg_n_in | input | 8 | Averaging count N |
| win_valid | output | 1 | Window result pulse |
| win_pf | output | 16 | Window power factor, signed Q1.15 |
| win_zero | output | 1 | Window apparent power was zero |
| win_p | output | 34 | Window mean active power, signed |
| win_s | output | 34 | Window mean arithmetic apparent power |
| avg_valid | output | 1 | Averaged result pulse |
| avg_pf | output | 16 | Energy-ratio power factor, signed Q1.15 |
| avg_zero | output | 1 | Accumulated apparent energy was zero |

## Verification
The assertions check four things on every cycle. The shared root unit must return the floor root of the operand it latched. The divider must never give the code -32768 and must give 0 whenever it flags a zero denominator. The result strobes must stay one cycle wide, and the window count must never pass N. The bench scenarios are needed for the rest. Only they can show that the numbers are right for whole windows of random, in-phase, anti-phase, zero-current and full-scale samples. They also show that strobe cycles with garbage data are ignored, that the average spans exactly N windows, and that a write of N drops a partly built average.

// File: rtl/apf_pkg.sv
package apf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SQ_GO,
        ST_SQ_RUN,
        ST_DW_GO,
        ST_DW_RUN,
        ST_DA_GO,
        ST_DA_RUN
    } ctl_st_e;

    localparam int PHASES = 3;
endpackage

// File: rtl/apf_phase_acc.sv
module apf_phase_acc #(
    parameter int SMP_W = 16,
    parameter int SUM_W = 38
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_en,
    input  logic                    smp_last,
    input  logic signed [SMP_W-1:0] v_in,
    input  logic signed [SMP_W-1:0] i_in,
    output logic [SUM_W-1:0]        v2_snap,
    output logic [SUM_W-1:0]        i2_snap,
    output logic signed [SUM_W-1:0] vi_snap
);
    localparam int PRD_W = 2 * SMP_W;

    typedef struct packed {
        logic [SUM_W-1:0] v2_acc;
        logic [SUM_W-1:0] i2_acc;
        logic [SUM_W-1:0] vi_acc;
        logic [SUM_W-1:0] v2_hold;
        logic [SUM_W-1:0] i2_hold;
        logic [SUM_W-1:0] vi_hold;
    } acc_s;

    acc_s acc_q, acc_d;
    logic signed [PRD_W-1:0] p_vv, p_ii, p_vi;
    logic [SUM_W-1:0] vv_x, ii_x, vi_x;
    logic [SUM_W-1:0] v2_nx, i2_nx, vi_nx;

    always_comb begin
        p_vv  = v_in * v_in;
        p_ii  = i_in * i_in;
        p_vi  = v_in * i_in;
        vv_x  = SUM_W'($unsigned(p_vv));
        ii_x  = SUM_W'($unsigned(p_ii));
        vi_x  = SUM_W'(p_vi);
        v2_nx = acc_q.v2_acc + vv_x;
        i2_nx = acc_q.i2_acc + ii_x;
        vi_nx = acc_q.vi_acc + vi_x;
        acc_d = acc_q;
        if (smp_en) begin
            if (smp_last) begin
                acc_d.v2_hold = v2_nx;
                acc_d.i2_hold = i2_nx;
                acc_d.vi_hold = vi_nx;
                acc_d.v2_acc  = '0;
                acc_d.i2_acc  = '0;
                acc_d.vi_acc  = '0;
            end else begin
                acc_d.v2_acc = v2_nx;
                acc_d.i2_acc = i2_nx;
                acc_d.vi_acc = vi_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign v2_snap = acc_q.v2_hold;
    assign i2_snap = acc_q.i2_hold;
    assign vi_snap = $signed(acc_q.vi_hold);
endmodule

// File: rtl/apf_isqrt.sv
module apf_isqrt #(
    parameter int IN_W = 38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IN_W-1:0]   x_in,
    output logic              done,
    output logic [IN_W/2-1:0] root
);
    localparam int RT_W  = IN_W / 2;
    localparam int CNT_W = $clog2(RT_W + 1);

    typedef struct packed {
        logic [IN_W-1:0]  x_hold;
        logic [IN_W-1:0]  op;
        logic [IN_W-1:0]  res;
        logic [IN_W-1:0]  one;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } sq_s;

    sq_s sq_q, sq_d;
    logic [IN_W-1:0] trial;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        trial     = sq_q.res + sq_q.one;
        if (start) begin
            sq_d.x_hold = x_in;
            sq_d.op     = x_in;
            sq_d.res    = '0;
            sq_d.one    = {2'b01, {(IN_W-2){1'b0}}};
            sq_d.cnt    = CNT_W'(RT_W);
            sq_d.busy   = 1'b1;
        end else if (sq_q.busy) begin
            if (sq_q.op >= trial) begin
                sq_d.op  = sq_q.op - trial;
                sq_d.res = (sq_q.res >> 1) + sq_q.one;
            end else begin
                sq_d.res = sq_q.res >> 1;
            end
            sq_d.one = sq_q.one >> 2;
            sq_d.cnt = sq_q.cnt - 1'b1;
            if (sq_q.cnt == CNT_W'(1)) begin
                sq_d.busy = 1'b0;
                sq_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign done = sq_q.done;
    assign root = sq_q.res[RT_W-1:0];

    logic [IN_W+1:0] rt_sq, rt1_sq, x_ext;
    always_comb begin
        x_ext  = (IN_W+2)'(sq_q.x_hold);
        rt_sq  = (IN_W+2)'(root) * (IN_W+2)'(root);
        rt1_sq = ((IN_W+2)'(root) + 1'b1) * ((IN_W+2)'(root) + 1'b1);
    end

    AST_SQRT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rt_sq <= x_ext) && (rt1_sq > x_ext)); // R3
endmodule

// File: rtl/apf_frac_div.sv
module apf_frac_div #(
    parameter int NUM_W  = 48,
    parameter int FRAC_W = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [NUM_W-1:0] num,
    input  logic [NUM_W-1:0]        den,
    output logic                    done,
    output logic signed [FRAC_W:0]  quo,
    output logic                    zero
);
    localparam int CNT_W = $clog2(FRAC_W + 1);
    localparam logic [FRAC_W:0] SAT = {1'b0, {FRAC_W{1'b1}}};

    typedef struct packed {
        logic [NUM_W-1:0]  rem;
        logic [NUM_W-1:0]  den_h;
        logic              neg;
        logic [FRAC_W-1:0] qacc;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              done;
        logic              zero;
        logic [FRAC_W:0]   quo;
    } dv_s;

    dv_s dv_q, dv_d;
    logic [NUM_W-1:0]  mag;
    logic [NUM_W:0]    r2;
    logic [FRAC_W-1:0] qn;
    logic              qb;

    always_comb begin
        dv_d      = dv_q;
        dv_d.done = 1'b0;
        mag = num[NUM_W-1] ? (~$unsigned(num) + 1'b1) : $unsigned(num);
        r2  = {dv_q.rem, 1'b0};
        qb  = (r2 >= {1'b0, dv_q.den_h});
        qn  = {dv_q.qacc[FRAC_W-2:0], qb};
        if (start) begin
            dv_d.neg = num[NUM_W-1];
            if (den == '0) begin
                dv_d.done = 1'b1;
                dv_d.zero = 1'b1;
                dv_d.quo  = '0;
            end else if (mag >= den) begin
                dv_d.done = 1'b1;
                dv_d.zero = 1'b0;
                dv_d.quo  = num[NUM_W-1] ? (~SAT + 1'b1) : SAT;
            end else begin
                dv_d.busy  = 1'b1;
                dv_d.zero  = 1'b0;
                dv_d.rem   = mag;
                dv_d.den_h = den;
                dv_d.qacc  = '0;
                dv_d.cnt   = CNT_W'(FRAC_W);
            end
        end else if (dv_q.busy) begin
            dv_d.rem  = qb ? NUM_W'(r2 - {1'b0, dv_q.den_h}) : NUM_W'(r2);
            dv_d.qacc = qn;
            dv_d.cnt  = dv_q.cnt - 1'b1;
            if (dv_q.cnt == CNT_W'(1)) begin
                dv_d.busy = 1'b0;
                dv_d.done = 1'b1;
                dv_d.quo  = dv_q.neg ? (~{1'b0, qn} + 1'b1) : {1'b0, qn};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign done = dv_q.done;
    assign quo  = $signed(dv_q.quo);
    assign zero = dv_q.zero;

    AST_DIV_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dv_q.quo != {1'b1, {FRAC_W{1'b0}}})); // R4
    AST_DIV_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zero) |-> (dv_q.quo == '0)); // R6
endmodule

// File: rtl/arith_pf_meter.sv
module arith_pf_meter
    import apf_pkg::*;
#(
    parameter int SMP_W    = 16,
    parameter int WIN_LOG2 = 6,
    parameter int NAVG_W   = 8,
    parameter int AVG_DEF  = 4,
    parameter int FRAC_W   = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] v_r,
    input  logic signed [SMP_W-1:0] v_s,
    input  logic signed [SMP_W-1:0] v_t,
    input  logic signed [SMP_W-1:0] i_r,
    input  logic signed [SMP_W-1:0] i_s,
    input  logic signed [SMP_W-1:0] i_t,
    input  logic                    avg_n_wr,
    input  logic [NAVG_W-1:0]       avg_n_in,
    output logic                    win_valid,
    output logic signed [FRAC_W:0]  win_pf,
    output logic                    win_zero,
    output logic signed [2*(((2*SMP_W+WIN_LOG2)+1)/2)+2-WIN_LOG2-1:0] win_p,
    output logic [2*(((2*SMP_W+WIN_LOG2)+1)/2)+2-WIN_LOG2-1:0]        win_s,
    output logic                    avg_valid,
    output logic signed [FRAC_W:0]  avg_pf,
    output logic                    avg_zero
);
    localparam int SQ_W    = 2 * SMP_W + WIN_LOG2;
    localparam int RT_W    = (SQ_W + 1) / 2;
    localparam int SQRT_IN = 2 * RT_W;
    localparam int PH_W    = 2 * RT_W + 2;
    localparam int ACC_W   = PH_W + NAVG_W;
    localparam int OUT_W   = PH_W - WIN_LOG2;

    typedef struct packed {
        ctl_st_e             st;
        logic [WIN_LOG2-1:0] smp_cnt;
        logic                win_rdy;
        logic [2:0]          rt_idx;
        logic [RT_W-1:0]     rv_tmp;
        logic [PH_W-1:0]     psum;
        logic [PH_W-1:0]     ssum;
        logic [ACC_W-1:0]    accp;
        logic [ACC_W-1:0]    accs;
        logic [NAVG_W-1:0]   avg_cnt;
        logic [NAVG_W-1:0]   avg_n;
        logic [FRAC_W:0]     win_pf;
        logic                win_zero;
        logic                win_valid;
        logic [OUT_W-1:0]    win_p;
        logic [OUT_W-1:0]    win_s;
        logic [FRAC_W:0]     avg_pf;
        logic                avg_zero;
        logic                avg_valid;
    } ctl_s;

    ctl_s ctl_q, ctl_d;

    // per-phase accumulation
    logic signed [SMP_W-1:0] v_all [PHASES];
    logic signed [SMP_W-1:0] i_all [PHASES];
    logic [SQ_W-1:0]         v2_s  [PHASES];
    logic [SQ_W-1:0]         i2_s  [PHASES];
    logic signed [SQ_W-1:0]  vi_s  [PHASES];
    logic                    smp_last;

    assign v_all[0] = v_r;
    assign v_all[1] = v_s;
    assign v_all[2] = v_t;
    assign i_all[0] = i_r;
    assign i_all[1] = i_s;
    assign i_all[2] = i_t;
    assign smp_last = smp_valid && (ctl_q.smp_cnt == {WIN_LOG2{1'b1}});

    for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
        apf_phase_acc #(.SMP_W(SMP_W), .SUM_W(SQ_W)) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_en   (smp_valid),
            .smp_last (smp_last),
            .v_in     (v_all[ph]),
            .i_in     (i_all[ph]),
            .v2_snap  (v2_s[ph]),
            .i2_snap  (i2_s[ph]),
            .vi_snap  (vi_s[ph])
        );
    end

    // shared root and divide units
    logic                    sq_start, sq_done;
    logic [SQRT_IN-1:0]      sq_x;
    logic [RT_W-1:0]         sq_root;
    logic                    dv_start, dv_done, dv_zero;
    logic signed [ACC_W-1:0] dv_num;
    logic [ACC_W-1:0]        dv_den;
    logic signed [FRAC_W:0]  dv_quo;

    apf_isqrt #(.IN_W(SQRT_IN)) u_sqrt (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sq_start),
        .x_in  (sq_x),
        .done  (sq_done),
        .root  (sq_root)
    );

    apf_frac_div #(.NUM_W(ACC_W), .FRAC_W(FRAC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dv_start),
        .num   (dv_num),
        .den   (dv_den),
        .done  (dv_done),
        .quo   (dv_quo),
        .zero  (dv_zero)
    );

    logic [2*RT_W-1:0]  rt_prod;
    logic [NAVG_W-1:0]  cnt_nx;

    always_comb begin
        case (ctl_q.rt_idx)
            3'd0:    sq_x = SQRT_IN'(v2_s[0]);
            3'd1:    sq_x = SQRT_IN'(i2_s[0]);
            3'd2:    sq_x = SQRT_IN'(v2_s[1]);
            3'd3:    sq_x = SQRT_IN'(i2_s[1]);
            3'd4:    sq_x = SQRT_IN'(v2_s[2]);
            default: sq_x = SQRT_IN'(i2_s[2]);
        endcase
        sq_start = (ctl_q.st == ST_SQ_GO);
        dv_start = (ctl_q.st == ST_DW_GO) || (ctl_q.st == ST_DA_GO);
        dv_num   = (ctl_q.st == ST_DA_GO) ? $signed(ctl_q.accp)
                                          : ACC_W'($signed(ctl_q.psum));
        dv_den   = (ctl_q.st == ST_DA_GO) ? ctl_q.accs : ACC_W'(ctl_q.ssum);
        rt_prod  = (2*RT_W)'(ctl_q.rv_tmp) * (2*RT_W)'(sq_root);
        cnt_nx   = ctl_q.avg_cnt + 1'b1;

        ctl_d           = ctl_q;
        ctl_d.win_valid = 1'b0;
        ctl_d.avg_valid = 1'b0;
        ctl_d.win_rdy   = smp_last;
        if (smp_valid) ctl_d.smp_cnt = ctl_q.smp_cnt + 1'b1;

        case (ctl_q.st)
            ST_IDLE: if (ctl_q.win_rdy) begin
                ctl_d.psum   = PH_W'($signed(vi_s[0])) + PH_W'($signed(vi_s[1]))
                             + PH_W'($signed(vi_s[2]));
                ctl_d.ssum   = '0;
                ctl_d.rt_idx = '0;
                ctl_d.st     = ST_SQ_GO;
            end
            ST_SQ_GO: ctl_d.st = ST_SQ_RUN;
            ST_SQ_RUN: if (sq_done) begin
                if (!ctl_q.rt_idx[0]) ctl_d.rv_tmp = sq_root;
                else                  ctl_d.ssum   = ctl_q.ssum + PH_W'(rt_prod);
                if (ctl_q.rt_idx == 3'd5) begin
                    ctl_d.st = ST_DW_GO;
                end else begin
                    ctl_d.rt_idx = ctl_q.rt_idx + 1'b1;
                    ctl_d.st     = ST_SQ_GO;
                end
            end
            ST_DW_GO: ctl_d.st = ST_DW_RUN;
            ST_DW_RUN: if (dv_done) begin
                ctl_d.win_pf    = dv_quo;
                ctl_d.win_zero  = dv_zero;
                ctl_d.win_valid = 1'b1;
                ctl_d.win_p     = OUT_W'($signed(ctl_q.psum) >>> WIN_LOG2);
                ctl_d.win_s     = OUT_W'(ctl_q.ssum >> WIN_LOG2);
                ctl_d.accp      = ctl_q.accp + ACC_W'($signed(ctl_q.psum));
                ctl_d.accs      = ctl_q.accs + ACC_W'(ctl_q.ssum);
                ctl_d.avg_cnt   = cnt_nx;
                ctl_d.st        = (cnt_nx >= ctl_q.avg_n) ? ST_DA_GO : ST_IDLE;
            end
            ST_DA_GO: ctl_d.st = ST_DA_RUN;
            ST_DA_RUN: if (dv_done) begin
                ctl_d.avg_pf    = dv_quo;
                ctl_d.avg_zero  = dv_zero;
                ctl_d.avg_valid = 1'b1;
                ctl_d.accp      = '0;
                ctl_d.accs      = '0;
                ctl_d.avg_cnt   = '0;
                ctl_d.st        = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (avg_n_wr) begin
            ctl_d.avg_n   = (avg_n_in == '0) ? NAVG_W'(1) : avg_n_in;
            ctl_d.accp    = '0;
            ctl_d.accs    = '0;
            ctl_d.avg_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
            ctl_q.avg_n <= NAVG_W'(AVG_DEF);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign win_valid = ctl_q.win_valid;
    assign win_pf    = $signed(ctl_q.win_pf);
    assign win_zero  = ctl_q.win_zero;
    assign win_p     = $signed(ctl_q.win_p);
    assign win_s     = ctl_q.win_s;
    assign avg_valid = ctl_q.avg_valid;
    assign avg_pf    = $signed(ctl_q.avg_pf);
    assign avg_zero  = ctl_q.avg_zero;

    AST_WIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> !win_valid); // R5
    AST_AVG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |=> !avg_valid); // R7
    AST_WIN_ZERO_PF: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_zero) |-> (win_pf == '0)); // R6
    AST_AVG_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.avg_n != '0) && (ctl_q.avg_cnt <= ctl_q.avg_n)); // R8
endmodule

// File: tb/tb_arith_pf_meter.sv
module tb_arith_pf_meter;
    localparam int OW = 34;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [15:0] v_r = '0, v_s = '0, v_t = '0;
    logic signed [15:0] i_r = '0, i_s = '0, i_t = '0;
    logic avg_n_wr = 1'b0;
    logic [7:0] avg_n_in = '0;
    logic win_valid, win_zero, avg_valid, avg_zero;
    logic signed [15:0] win_pf, avg_pf;
    logic signed [OW-1:0] win_p;
    logic [OW-1:0] win_s;

    always #5 clk = ~clk;

    arith_pf_meter dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .v_r(v_r), .v_s(v_s), .v_t(v_t), .i_r(i_r), .i_s(i_s), .i_t(i_t),
        .avg_n_wr(avg_n_wr), .avg_n_in(avg_n_in),
        .win_valid(win_valid), .win_pf(win_pf), .win_zero(win_zero),
        .win_p(win_p), .win_s(win_s),
        .avg_valid(avg_valid), .avg_pf(avg_pf), .avg_zero(avg_zero)
    );

    int checks = 0;
    int errors = 0;
    int vs [3][64];
    int is_ [3][64];
    int e_wpf [64]; bit e_wz [64]; longint e_wp [64]; longint e_ws [64];
    int e_apf [64]; bit e_az [64];
    int n_wexp = 0, n_wgot = 0, n_aexp = 0, n_agot = 0;
    int m_n = 4, m_cnt = 0;
    longint m_p = 0, m_s = 0;

    function automatic longint isq(longint x);
        longint r = 0;
        for (int b = 20; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= x) r = t;
        end
        return r;
    endfunction

    function automatic int pf_of(longint p, longint s);
        longint mag, q;
        if (s == 0) return 0;
        mag = (p < 0) ? -p : p;
        q = (mag >= s) ? 32767 : ((mag << 15) / s);
        return (p < 0) ? -int'(q) : int'(q);
    endfunction

    task automatic chk(string req, string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic gen(int kind);
        for (int ph = 0; ph < 3; ph++) begin
            for (int k = 0; k < 64; k++) begin
                int v, c;
                case (kind)
                    1: begin v = 1000; c = 1000; end
                    2: begin v = 1000; c = -1000; end
                    3: begin v = int'($urandom_range(4000, 0)) - 2000; c = 0; end
                    4: begin v = int'($urandom_range(65534, 0)) - 32767;
                             c = int'($urandom_range(65534, 0)) - 32767; end
                    default: begin
                        v = int'($urandom_range(4000, 0)) - 2000;
                        c = (v * int'($urandom_range(8, 1))) / 8
                          + int'($urandom_range(600, 0)) - 300;
                    end
                endcase
                vs[ph][k] = v;
                is_[ph][k] = c;
            end
        end
    endtask

    // builds expected window and average results from R1-style sums
    task automatic send_window(int kind);
        longint p = 0, s = 0;
        gen(kind);
        for (int ph = 0; ph < 3; ph++) begin
            longint a = 0, b = 0;
            for (int k = 0; k < 64; k++) begin
                a += longint'(vs[ph][k]) * vs[ph][k];
                b += longint'(is_[ph][k]) * is_[ph][k];
                p += longint'(vs[ph][k]) * is_[ph][k];
            end
            s += isq(a) * isq(b);
        end
        e_wpf[n_wexp] = pf_of(p, s);
        e_wz[n_wexp]  = (s == 0);
        e_wp[n_wexp]  = p >>> 6;
        e_ws[n_wexp]  = s >> 6;
        n_wexp++;
        m_p += p; m_s += s; m_cnt++;
        if (m_cnt >= m_n) begin
            e_apf[n_aexp] = pf_of(m_p, m_s);
            e_az[n_aexp]  = (m_s == 0);
            n_aexp++;
            m_p = 0; m_s = 0; m_cnt = 0;
        end
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            v_r = 16'(vs[0][k]); v_s = 16'(vs[1][k]); v_t = 16'(vs[2][k]);
            i_r = 16'(is_[0][k]); i_s = 16'(is_[1][k]); i_t = 16'(is_[2][k]);
            @(negedge clk);
            smp_valid = 1'b0;  // R1: garbage on idle cycles must be ignored
            v_r = 16'($urandom); v_s = 16'($urandom); v_t = 16'($urandom);
            i_r = 16'($urandom); i_s = 16'($urandom); i_t = 16'($urandom);
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic set_n(int n);
        @(negedge clk);
        avg_n_wr = 1'b1;
        avg_n_in = 8'(n);
        @(negedge clk);
        avg_n_wr = 1'b0;
        m_n = (n == 0) ? 1 : n;
        m_cnt = 0; m_p = 0; m_s = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n && win_valid) begin
            if (n_wgot < n_wexp) begin
                chk("R4", "win_pf", longint'(win_pf), longint'(e_wpf[n_wgot]));
                chk("R6", "win_zero", longint'(win_zero), longint'(e_wz[n_wgot]));
                chk("R2", "win_p", longint'(win_p), e_wp[n_wgot]);
                chk("R3", "win_s", longint'(win_s), e_ws[n_wgot]);
            end else begin
                chk("R5", "unexpected window pulse", longint'(n_wgot), longint'(n_wexp));
            end
            n_wgot++;
        end
        if (rst_n && avg_valid) begin
            if (n_agot < n_aexp) begin
                chk("R7", "avg_pf", longint'(avg_pf), longint'(e_apf[n_agot]));
                chk("R6", "avg_zero", longint'(avg_zero), longint'(e_az[n_agot]));
            end else begin
                chk("R8", "unexpected average pulse", longint'(n_agot), longint'(n_aexp));
            end
            n_agot++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5821));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9", "win_valid", longint'(win_valid), 0);
        chk("R9", "avg_valid", longint'(avg_valid), 0);
        chk("R9", "win_pf", longint'(win_pf), 0);
        chk("R9", "avg_pf", longint'(avg_pf), 0);
        chk("R9", "zero flags", longint'({win_zero, avg_zero}), 0);
        // default N of 4 (R8): in-phase, anti-phase, zero current, random
        send_window(1);
        send_window(2);
        send_window(3);
        send_window(0);
        send_window(4);
        send_window(0);
        repeat (400) @(negedge clk);
        // R8: restart drops the two pending windows
        set_n(2);
        send_window(0);
        send_window(4);
        repeat (400) @(negedge clk);
        // R8: zero taken as one; R6 zero energy average
        set_n(0);
        send_window(3);
        send_window(0);
        repeat (400) @(negedge clk);
        set_n(3);
        for (int w = 0; w < 6; w++) send_window((w % 3 == 2) ? 4 : 0);
        repeat (400) @(negedge clk);
        chk("R5", "window pulse count", longint'(n_wgot), longint'(n_wexp));
        chk("R7", "average pulse count", longint'(n_agot), longint'(n_aexp));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule